// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Bank

This block holds a bank of programmable performance counters. The counters sit at slot indices 3 upward. Index 3 is the first counter, and each further configured counter takes the next index. Each counter has its own event pulse input. On every clock edge where that pulse is high, the counter adds one, unless something blocks it. Two things can block it: a bit in a shared count-inhibit register, or a per-counter set of mode filter bits. The filter bits can stop counting in machine mode, in supervisor or user mode, and in the virtualized supervisor or virtualized user mode.

A counter can wrap past its largest value. If its sticky overflow flag is clear at that moment, the flag is set and a shared overflow interrupt pending line goes high. A counter that wraps again while its flag is still set raises no new interrupt.

The width mode input selects how the 64-bit counter is treated. With it low, the counter is one full 64-bit counter. With it high, the counter is two 32-bit halves that software writes separately. Software writes the counters, the filter bits and the inhibit register through plain write strobes. It clears the interrupt with a dedicated clear input.

Top module: `hpc_bank`

## Requirements
- R1: After a synchronous reset, all counts are zero, all overflow flags and all filter bits are clear, the inhibit register is zero, and the interrupt pending line is low.
- R2: Slot k (index 3+k) adds one at each clock edge where its pulse is high, its inhibit bit is clear, no filter bit applies, and no counter write targets it. The result is visible after that edge.
- R3: Bit 3+k of the count-inhibit register set (written through inh_wdata) makes slot k ignore its pulses. Its count holds.
- R4: The filter field is bit5 overflow, bit4 machine inhibit, bit3 supervisor inhibit, bit2 user inhibit, bit1 virtualized-supervisor inhibit, bit0 virtualized-user inhibit. The mode codes are 2'b11 machine, 2'b01 supervisor and 2'b00 user. Machine mode applies bit4 whatever the virtualization flag. Supervisor mode applies bit1 when virt_on is high and bit3 when it is low. User mode applies bit0 when virt_on is high and bit2 when it is low.
- R5: With xlen32 low, a counter at all ones becomes zero on its next counted pulse. Otherwise it adds one with a full 64-bit carry.
- R6: With xlen32 high, a counted pulse works as follows. If the low half is not all ones, only the low half adds one. If the low half is all ones and the high half is not, the high half adds one and the low half is left unchanged. If both halves are all ones, both become zero and this counts as a wrap.
- R7: A wrap while the slot's overflow flag is clear sets the flag and sets the interrupt pending line. A wrap with the flag already set leaves the pending line unchanged.
- R8: An overflow flag stays set until a filter-field write to that slot loads bit5 = 0. The pending line holds until irq_clr. A new first overflow in the same cycle as irq_clr leaves the pending line set.
- R9: A counter write in the same cycle as a pulse takes precedence, and that pulse is lost. cnt_wr[0] loads bits 31:0 and cnt_wr[1] loads bits 63:32 from the same bit positions of cnt_wdata.
- R10: Counter and filter writes to an index below 3 or above the last slot change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlen32 | input | 1 | 1 = split 32-bit halves, 0 = single 64-bit counter |
| priv_mode | input | 2 | Current mode: 11 machine, 01 supervisor, 00 user |
| virt_on | input | 1 | Virtualization active |
| evt_pulse | input | NUM_CTR | One increment pulse per slot, bit k for index 3+k |
| inh_we | input | 1 | Write strobe for the count-inhibit register |
| inh_wdata | input | NUM_CTR+3 | Inhibit data, bit 3+k for slot k |
| cnt_wr | input | 2 | Counter write lanes: bit0 low half, bit1 high half |
| cnt_widx | input | IDX_W | Counter write index |
| cnt_wdata | input | CTR_W | Counter write data |
| evc_we | input | 1 | Filter field write strobe |
| evc_widx | input | IDX_W | Filter field write index |
| evc_wdata | input | 6 | Filter field data, layout as in R4 |
| irq_clr | input | 1 | Clears the interrupt pending line |
| cnt_val | output | NUM_CTR*CTR_W | Counter values, slot k at bits k*CTR_W upward |
| ovf_flag | output | NUM_CTR | Sticky overflow flags |
| irq_pend | output | 1 | Overflow interrupt pending |

## Verification
Three pairs of events can meet in one cycle, and the bench drives each pair on the same edge. A counter write can arrive together with a counted pulse. A fresh first overflow on one slot can coincide with irq_clr. A filter write that clears the overflow flag can coincide with other counting. The behavioural model applies the stated precedence: the write wins over the pulse, and the set wins over the clear. Counts, flags and the pending line are compared against the model after every edge, so a wrong precedence shows in the very next cycle.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [1:0] MODE_U = 2'b00;
  localparam logic [1:0] MODE_S = 2'b01;
  localparam logic [1:0] MODE_M = 2'b11;

  // per-slot filter field, bit5 down to bit0
  typedef struct packed {
    logic ovf;
    logic m_off;
    logic s_off;
    logic u_off;
    logic vs_off;
    logic vu_off;
  } evc_t;
endpackage

// File: rtl/hpc_filter.sv
module hpc_filter
  import hpc_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  evc_t       ctl,
  output logic       allow
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    case (priv)
      MODE_M:  allow = !ctl.m_off;
      MODE_S:  allow = virt ? !ctl.vs_off : !ctl.s_off;
      MODE_U:  allow = virt ? !ctl.vu_off : !ctl.u_off;
      default: allow = 1'b1;
    endcase
  end
endmodule

// File: rtl/hpc_slot.sv
module hpc_slot
  import hpc_pkg::*;
#(
  parameter int CTR_W  = 64,
  parameter int IDX_W  = 5,
  parameter int MY_IDX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xlen32,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             pulse,
  input  logic             inh_bit,
  input  logic [1:0]       cnt_wr,
  input  logic [IDX_W-1:0] cnt_widx,
  input  logic [CTR_W-1:0] cnt_wdata,
  input  logic             evc_we,
  input  logic [IDX_W-1:0] evc_widx,
  input  evc_t             evc_wdata,
  output logic [CTR_W-1:0] cnt_q,
  output logic             of_q,
  output logic             wrap_new
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF_W = CTR_W / 2;
  localparam logic [IDX_W-1:0] MY_SEL = IDX_W'(MY_IDX);

  evc_t              ctl_q, ctl_d;
  logic [CTR_W-1:0]  cnt_d;
  logic [HALF_W-1:0] lo, hi;
  logic              allow, inc_ok, cnt_hit, evc_hit, wrap;

  assign lo      = cnt_q[HALF_W-1:0];
  assign hi      = cnt_q[CTR_W-1:HALF_W];
  assign cnt_hit = (cnt_widx == MY_SEL) && (cnt_wr != 2'b00);
  assign evc_hit = evc_we && (evc_widx == MY_SEL);
  assign inc_ok  = pulse && !inh_bit && allow;
  assign of_q    = ctl_q.ovf;

  hpc_filter u_filter (
    .priv  (priv),
    .virt  (virt),
    .ctl   (ctl_q),
    .allow (allow)
  );

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (cnt_hit) begin
      if (cnt_wr[0]) cnt_d[HALF_W-1:0]     = cnt_wdata[HALF_W-1:0];
      if (cnt_wr[1]) cnt_d[CTR_W-1:HALF_W] = cnt_wdata[CTR_W-1:HALF_W];
    end else if (inc_ok) begin
      if (!xlen32) begin
        if (&cnt_q) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (&lo) begin
        if (&hi) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = {hi + 1'b1, lo};
        end
      end else begin
        cnt_d = {hi, lo + 1'b1};
      end
    end
  end

  always_comb begin
    ctl_d = ctl_q;
    if (evc_hit)   ctl_d = evc_wdata;
    else if (wrap) ctl_d.ovf = 1'b1;
  end

  assign wrap_new = wrap && !ctl_q.ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ctl_q <= ctl_d;
    end
  end

  // R3
  inh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && inh_bit && !cnt_hit) |=> $stable(cnt_q));

  // R5
  wrap64_chk: assert property (@(posedge clk) disable iff (rst)
    (!xlen32 && pulse && !inh_bit && allow && !cnt_hit && !evc_hit && (&cnt_q))
    |=> (cnt_q == '0) && of_q);

  // R6
  half_chk: assert property (@(posedge clk) disable iff (rst)
    (xlen32 && inc_ok && !cnt_hit && !(&lo)) |=> (cnt_q[CTR_W-1:HALF_W] == $past(hi)));

  // R8
  of_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (of_q && !evc_hit) |=> of_q);

  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt_wr == 2'b11) && (cnt_widx == MY_SEL)) |=> (cnt_q == $past(cnt_wdata)));
endmodule

// File: rtl/hpc_irq.sv
module hpc_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic         pend
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (rst)           pend <= 1'b0;
    else if (|set_vec) pend <= 1'b1;
    else if (clr)      pend <= 1'b0;
  end

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> pend);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/hpc_bank.sv
module hpc_bank
  import hpc_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 64,
  parameter int IDX_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     xlen32,
  input  logic [1:0]               priv_mode,
  input  logic                     virt_on,
  input  logic [NUM_CTR-1:0]       evt_pulse,
  input  logic                     inh_we,
  input  logic [NUM_CTR+2:0]       inh_wdata,
  input  logic [1:0]               cnt_wr,
  input  logic [IDX_W-1:0]         cnt_widx,
  input  logic [CTR_W-1:0]         cnt_wdata,
  input  logic                     evc_we,
  input  logic [IDX_W-1:0]         evc_widx,
  input  logic [5:0]               evc_wdata,
  input  logic                     irq_clr,
  output logic [NUM_CTR*CTR_W-1:0] cnt_val,
  output logic [NUM_CTR-1:0]       ovf_flag,
  output logic                     irq_pend
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BASE = 3;

  logic [NUM_CTR-1:0] inh_q;
  logic [NUM_CTR-1:0] wrap_new;
  logic               unused_inh;

  assign unused_inh = ^inh_wdata[BASE-1:0];

  always_ff @(posedge clk) begin
    if (rst)         inh_q <= '0;
    else if (inh_we) inh_q <= inh_wdata[BASE +: NUM_CTR];
  end

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_slot
    hpc_slot #(
      .CTR_W  (CTR_W),
      .IDX_W  (IDX_W),
      .MY_IDX (BASE + k)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .xlen32    (xlen32),
      .priv      (priv_mode),
      .virt      (virt_on),
      .pulse     (evt_pulse[k]),
      .inh_bit   (inh_q[k]),
      .cnt_wr    (cnt_wr),
      .cnt_widx  (cnt_widx),
      .cnt_wdata (cnt_wdata),
      .evc_we    (evc_we),
      .evc_widx  (evc_widx),
      .evc_wdata (evc_wdata),
      .cnt_q     (cnt_val[k*CTR_W +: CTR_W]),
      .of_q      (ovf_flag[k]),
      .wrap_new  (wrap_new[k])
    );
  end

  hpc_irq #(.N(NUM_CTR)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_vec (wrap_new),
    .clr     (irq_clr),
    .pend    (irq_pend)
  );
endmodule

// File: tb/test_hpc_bank.sv
module test_hpc_bank;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N = 4, W = 64, IW = 5, BASE = 3, INH_W = N + 3;

  logic clk = 1'b0, rst = 1'b1, xlen32 = 1'b0, virt_on = 1'b0;
  logic [1:0] priv_mode = 2'b11;
  logic [N-1:0] evt_pulse = '0;
  logic inh_we = 1'b0;
  logic [INH_W-1:0] inh_wdata = '0;
  logic [1:0] cnt_wr = 2'b00;
  logic [IW-1:0] cnt_widx = '0, evc_widx = '0;
  logic [W-1:0] cnt_wdata = '0;
  logic evc_we = 1'b0, irq_clr = 1'b0;
  logic [5:0] evc_wdata = '0;
  logic [N*W-1:0] cnt_val;
  logic [N-1:0] ovf_flag;
  logic irq_pend;

  hpc_bank i_hpc_bank (
    .clk(clk), .rst(rst), .xlen32(xlen32), .priv_mode(priv_mode), .virt_on(virt_on),
    .evt_pulse(evt_pulse), .inh_we(inh_we), .inh_wdata(inh_wdata), .cnt_wr(cnt_wr),
    .cnt_widx(cnt_widx), .cnt_wdata(cnt_wdata), .evc_we(evc_we), .evc_widx(evc_widx),
    .evc_wdata(evc_wdata), .irq_clr(irq_clr), .cnt_val(cnt_val), .ovf_flag(ovf_flag),
    .irq_pend(irq_pend)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit started = 0;

  // behavioural reference state
  logic [W-1:0] m_cnt [N];
  bit [5:0] m_ctl [N];
  bit m_irq;
  bit [INH_W-1:0] m_inh;

  always @(posedge clk) begin
    bit any_new, wrap, blocked;
    logic [31:0] lo, hi;
    started = 1;
    if (rst) begin
      for (int k = 0; k < N; k++) begin m_cnt[k] = '0; m_ctl[k] = '0; end
      m_irq = 0; m_inh = '0;
    end else begin
      any_new = 0;
      for (int k = 0; k < N; k++) begin
        wrap = 0;
        case (priv_mode)
          2'b11:   blocked = m_ctl[k][4];
          2'b01:   blocked = virt_on ? m_ctl[k][1] : m_ctl[k][3];
          2'b00:   blocked = virt_on ? m_ctl[k][0] : m_ctl[k][2];
          default: blocked = 0;
        endcase
        lo = m_cnt[k][31:0];
        hi = m_cnt[k][63:32];
        if (cnt_wr != 2'b00 && cnt_widx == BASE + k) begin
          if (cnt_wr[0]) m_cnt[k][31:0]  = cnt_wdata[31:0];
          if (cnt_wr[1]) m_cnt[k][63:32] = cnt_wdata[63:32];
        end else if (evt_pulse[k] && !m_inh[BASE+k] && !blocked) begin
          if (!xlen32) begin
            if (m_cnt[k] == {W{1'b1}}) begin m_cnt[k] = '0; wrap = 1; end
            else m_cnt[k] = m_cnt[k] + 1;
          end else if (lo == 32'hFFFF_FFFF) begin
            if (hi == 32'hFFFF_FFFF) begin m_cnt[k] = '0; wrap = 1; end
            else m_cnt[k] = {hi + 32'd1, lo};
          end else m_cnt[k] = {hi, lo + 32'd1};
        end
        if (wrap && !m_ctl[k][5]) any_new = 1;
        if (evc_we && evc_widx == BASE + k) m_ctl[k] = evc_wdata;
        else if (wrap) m_ctl[k][5] = 1;
      end
      if (any_new) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (inh_we) m_inh = inh_wdata;
    end
  end

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      for (int k = 0; k < N; k++) begin
        chk($sformatf("count[%0d]", k), cnt_val[k*W +: W], m_cnt[k]);
        chk($sformatf("ovf[%0d]", k), {63'd0, ovf_flag[k]}, {63'd0, m_ctl[k][5]});
      end
      chk("irq", {63'd0, irq_pend}, {63'd0, m_irq});
    end
  end

  task automatic go(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic quiet();
    inh_we = 0; cnt_wr = 2'b00; evc_we = 0; irq_clr = 0;
  endtask

  task automatic wr_cnt(int idx, logic [1:0] lanes, logic [W-1:0] d);
    cnt_wr = lanes; cnt_widx = IW'(idx); cnt_wdata = d;
  endtask

  task automatic wr_evc(int idx, logic [5:0] d);
    evc_we = 1; evc_widx = IW'(idx); evc_wdata = d;
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog R1-timeout actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    go(3); rst = 0; go(2);

    cur_req = "R2";
    evt_pulse = 4'b1111; go(3);
    evt_pulse = 4'b0101; go(1);
    evt_pulse = 4'b1010; go(1);
    evt_pulse = 4'b0000; go(1);

    cur_req = "R3";
    inh_we = 1; inh_wdata = 7'b0010000; evt_pulse = 4'b1111; go(1);
    quiet(); go(3);
    inh_we = 1; inh_wdata = 7'b1000111; go(1);
    quiet(); go(2);
    inh_we = 1; inh_wdata = '0; go(1);
    quiet(); go(1);

    cur_req = "R4";
    wr_evc(3, 6'b010000); go(1);
    wr_evc(4, 6'b001000); go(1);
    wr_evc(5, 6'b000100); go(1);
    wr_evc(6, 6'b000011); go(1);
    quiet();
    for (int m = 0; m < 6; m++) begin
      priv_mode = (m < 2) ? 2'b11 : (m < 4) ? 2'b01 : 2'b00;
      virt_on = m[0];
      go(2);
    end
    for (int i = 0; i < 4; i++) begin wr_evc(BASE + i, 6'b0); go(1); end
    quiet(); priv_mode = 2'b11; virt_on = 0; go(1);

    cur_req = "R9";
    wr_cnt(4, 2'b11, 64'h1234_5678_9ABC_DEF0); go(1);
    wr_cnt(5, 2'b01, 64'h0000_1111_AAAA_BBBB); go(1);
    wr_cnt(6, 2'b10, 64'hCCCC_DDDD_0000_2222); go(1);
    quiet(); go(2);

    cur_req = "R10";
    evt_pulse = 4'b0000;
    wr_cnt(2, 2'b11, 64'hDEAD_BEEF_0000_0001); go(1);
    wr_cnt(0, 2'b11, 64'h5); go(1);
    wr_cnt(7, 2'b11, 64'h7); go(1);
    wr_cnt(31, 2'b11, 64'h9); go(1);
    quiet(); wr_evc(2, 6'b111111); go(1);
    wr_evc(7, 6'b111111); go(1);
    quiet(); evt_pulse = 4'b1111; go(2);

    cur_req = "R5";
    evt_pulse = 4'b0000;
    wr_cnt(3, 2'b11, 64'hFFFF_FFFF_FFFF_FFFE); go(1);
    quiet(); wr_cnt(6, 2'b11, 64'h0000_0000_FFFF_FFFF); go(1);
    quiet(); evt_pulse = 4'b1001; go(3);

    cur_req = "R7";
    evt_pulse = 4'b0000; irq_clr = 1; go(1);
    quiet(); wr_cnt(3, 2'b11, '1); go(1);
    quiet(); evt_pulse = 4'b0001; go(2);
    evt_pulse = 4'b0000; go(1);

    cur_req = "R8";
    wr_cnt(4, 2'b11, '1); go(1);
    quiet(); irq_clr = 1; evt_pulse = 4'b0010; go(1);
    quiet(); evt_pulse = 4'b0101; wr_evc(3, 6'b000000); go(1);
    quiet(); go(3);
    irq_clr = 1; go(1);
    quiet(); go(2);

    cur_req = "R6";
    xlen32 = 1; evt_pulse = 4'b0000;
    wr_cnt(5, 2'b11, 64'h0000_0005_FFFF_FFFF); go(1);
    quiet(); evt_pulse = 4'b0100; go(2);
    evt_pulse = 4'b0000; wr_cnt(5, 2'b10, 64'hFFFF_FFFF_0000_0000); go(1);
    wr_cnt(5, 2'b01, 64'h0000_0000_FFFF_FFFD); go(1);
    quiet(); evt_pulse = 4'b0101; go(4);
    evt_pulse = 4'b0000; go(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule